// File: doc/BRIEF.md
# Short SPI command engine

This block is a host-side SPI master for short serial-flash commands, run from eight byte-wide registers. Software fills in an opcode, up to three address bytes and one trailing data byte. It then writes a control byte. That byte picks one of four outbound frame shapes, the number of response bytes to collect (zero to three), and a slow or a fast serial clock.

The engine frames the command with chip select and clocks it out in SPI mode 0, most significant bit first. Incoming MISO bytes are gathered and placed in read-back registers. The busy flag in the control register stays set until everything is finished. Software polls busy, and once it reads low it reads the response bytes.

Only outbound frames of 1, 2, 4 or 5 bytes can be built. The three address bytes are held in registers whose offsets run opposite to their order on the wire. The trailing data byte has its own register.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every register offset reads 0x00, chip select is high (inactive) and SCLK is low.
- R2: Control bits 1:0 choose the outbound bytes. Code 0 sends the opcode (offset 1) only. Code 1 sends the opcode, then the data byte (offset 7). Code 2 sends the opcode, then three address bytes. Code 3 sends the opcode, three address bytes, then the data byte. MOSI is 0 during every response byte.
- R3: The address bytes go out starting with offset 4, then offset 3, and offset 2 goes out last.
- R4: Control bits 3:2 give the response count N (0 to 3). The N bytes that follow the outbound frame are stored at offsets 5, 6 and 7, in the order they arrive. Slots at or beyond N keep their old values. Bus writes to offsets 5 and 6 have no effect.
- R5: Control bits 7:4 start a transfer only when they equal 4 or 5. With 4, every SCLK half-period lasts SLOW_HALF clock cycles. With 5, it lasts FAST_HALF cycles. Any other value leaves the engine idle, and the whole control write is discarded.
- R6: Offset 0 reads as {busy, 3'b000, response count, frame code}. Busy reads 1 from the cycle after an accepted control write, and it equals the inverse of chip select at all times.
- R7: While busy is set, control writes and writes to offsets 1 to 4 and 7 are discarded. The registers keep their values, and no second transfer starts.
- R8: Mode 0 timing applies. SCLK is low whenever chip select is high, and MOSI changes only while SCLK is low. Chip select falls one half-period before the first rising edge and rises one half-period after the last falling edge.
- R9: Busy falls in the same cycle that the response registers take their new bytes. A read made as soon as busy reads 0 therefore returns the current transfer's data.
- R10: A transfer gives exactly 8 × (outbound bytes + N) rising SCLK edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach from the ports is a bus write that lands while a transfer is in flight. Such a write must change neither the frame on the wire nor the stored registers, and it must not start a second transfer. The bench starts a five-byte frame with a response phase. While busy is set, it writes a new start code, a new opcode and a new data byte. The device model then checks that the data byte still leaves with its original value. The bench reads the opcode and control registers back after busy falls, and it watches chip select for a stray second frame. A further check samples the response registers in the very first cycle that busy reads low.

// File: rtl/spi_cmd_pkg.sv
// Shared types and constants for the short SPI command engine.
// Assumes an eight-entry byte register space addressed by three bits.
package spi_cmd_pkg;

    // Outbound frame shape selected by control bits 1:0
    typedef enum logic [1:0] {
        FRM_OP           = 2'd0,
        FRM_OP_DATA      = 2'd1,
        FRM_OP_ADDR      = 2'd2,
        FRM_OP_ADDR_DATA = 2'd3
    } frame_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } seq_state_e;

    // Transfer settings latched on an accepted start
    typedef struct packed {
        logic       fast;
        logic [1:0] rcnt;
        frame_e     frame;
    } xfer_cfg_t;

    localparam int unsigned MAX_RX = 3;

    // Register offsets; the address order is behaviour (hi goes out first)
    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_OPC  = 3'd1;
    localparam logic [2:0] OFS_ALO  = 3'd2;
    localparam logic [2:0] OFS_AMID = 3'd3;
    localparam logic [2:0] OFS_AHI  = 3'd4;
    localparam logic [2:0] OFS_RX0  = 3'd5;
    localparam logic [2:0] OFS_RX1  = 3'd6;
    localparam logic [2:0] OFS_RX2D = 3'd7;

    localparam logic [3:0] GO_SLOW = 4'h4;
    localparam logic [3:0] GO_FAST = 4'h5;

    // Number of outbound bytes for a frame shape
    function automatic logic [2:0] tx_len(frame_e f);
        case (f)
            FRM_OP:      tx_len = 3'd1;
            FRM_OP_DATA: tx_len = 3'd2;
            FRM_OP_ADDR: tx_len = 3'd4;
            default:     tx_len = 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
// Half-period tick generator for SCLK.
// Emits one tick every SLOW_HALF or FAST_HALF cycles while run is high.
// Assumes load is pulsed in the cycle a transfer is accepted.
module spi_half_timer #(
    parameter int unsigned SLOW_HALF = 4,
    parameter int unsigned FAST_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic fast_sel,
    input  logic run,
    output logic tick
);
    localparam int unsigned MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int unsigned CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    // Pick the half-period length for the selected rate
    assign reload = fast_sel ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
    assign tick   = run && (cnt == '0);

    // Count down one half-period, reloading on every tick
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= reload;
        else if (run)     cnt <= tick ? reload : cnt - 1'b1;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_HALF - 1));

endmodule

// File: rtl/spi_frame_seq.sv
// Bit sequencer: drives CS, SCLK (mode 0, MSB first) and MOSI, and collects
// response bytes into a staging array.
// Assumes the source registers stay frozen while busy is high.
module spi_frame_seq
    import spi_cmd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  xfer_cfg_t               cfg,
    input  logic [7:0]              opcode,
    input  logic [7:0]              addr_hi,
    input  logic [7:0]              addr_mid,
    input  logic [7:0]              addr_lo,
    input  logic [7:0]              data_byte,
    input  logic                    tick,
    input  logic                    miso,
    output logic                    cs_n,
    output logic                    sclk,
    output logic                    mosi,
    output logic                    busy,
    output logic                    done,
    output logic [MAX_RX-1:0][7:0]  rx_stage
);
    seq_state_e state;
    logic [2:0] byte_idx;
    logic [2:0] bit_idx;
    logic [7:0] tx_sh;
    logic [7:0] rx_sh;
    logic [2:0] tx_n;
    logic [2:0] last_idx;
    logic [2:0] nidx;
    logic [7:0] next_byte;

    assign tx_n     = tx_len(cfg.frame);
    assign last_idx = tx_n + {1'b0, cfg.rcnt} - 3'd1;
    assign nidx     = byte_idx + 3'd1;
    assign mosi     = tx_sh[7];
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_TRAIL) && tick;

    // Choose the byte that follows the current one on MOSI
    always_comb begin
        if (nidx >= tx_n)                  next_byte = 8'h00;
        else if (cfg.frame == FRM_OP_DATA) next_byte = data_byte;
        else begin
            case (nidx)
                3'd1:    next_byte = addr_hi;
                3'd2:    next_byte = addr_mid;
                3'd3:    next_byte = addr_lo;
                default: next_byte = data_byte;
            endcase
        end
    end

    // Frame state machine: shift on falling edges, sample on rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_stage <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_SHIFT;
                    cs_n     <= 1'b0;
                    byte_idx <= '0;
                    bit_idx  <= '0;
                    tx_sh    <= opcode;
                end
                ST_SHIFT: if (tick) begin
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            for (int k = 0; k < MAX_RX; k++) begin
                                if (byte_idx == tx_n + 3'(k)) rx_stage[k] <= rx_sh;
                            end
                            if (byte_idx == last_idx) begin
                                state <= ST_TRAIL;
                            end else begin
                                byte_idx <= nidx;
                                bit_idx  <= '0;
                                tx_sh    <= next_byte;
                            end
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end
                ST_TRAIL: if (tick) begin
                    cs_n  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R10
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_idx == last_idx && bit_idx == 3'd7));

endmodule

// File: rtl/spi_cmd_regs.sv
// Byte register file: command bytes, control decode, response slots.
// Assumes one bus write per cycle; writes are dropped while busy is high.
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [2:0]              rd_addr,
    input  logic                    busy,
    input  logic                    done,
    input  logic [MAX_RX-1:0][7:0]  rx_stage,
    output logic [7:0]              rd_data,
    output logic [7:0]              opcode,
    output logic [7:0]              addr_hi,
    output logic [7:0]              addr_mid,
    output logic [7:0]              addr_lo,
    output logic [7:0]              data_byte,
    output xfer_cfg_t               cfg,
    output logic                    start,
    output logic                    start_fast
);
    logic [MAX_RX-1:0][7:0] rx_q;
    logic [MAX_RX-1:0]      slot_we;
    logic                   go_code;

    assign go_code    = (wr_data[7:4] == GO_SLOW) || (wr_data[7:4] == GO_FAST);
    assign start      = wr_en && !busy && (wr_addr == OFS_CTRL) && go_code;
    assign start_fast = (wr_data[7:4] == GO_FAST);

    // One commit enable per response slot, below the latched count
    for (genvar g = 0; g < MAX_RX; g++) begin : g_slot
        assign slot_we[g] = done && (2'(g) < cfg.rcnt);
    end

    // Latch transfer settings on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg <= '0;
        else if (start) cfg <= '{fast: start_fast, rcnt: wr_data[3:2], frame: frame_e'(wr_data[1:0])};
    end

    // Command bytes, writable only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode    <= '0;
            addr_hi   <= '0;
            addr_mid  <= '0;
            addr_lo   <= '0;
            data_byte <= '0;
        end else if (wr_en && !busy) begin
            case (wr_addr)
                OFS_OPC:  opcode    <= wr_data;
                OFS_AHI:  addr_hi   <= wr_data;
                OFS_AMID: addr_mid  <= wr_data;
                OFS_ALO:  addr_lo   <= wr_data;
                OFS_RX2D: data_byte <= wr_data;
                default:  ;
            endcase
        end
    end

    // Response slots take staged bytes when the transfer closes
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else begin
            for (int k = 0; k < MAX_RX; k++) begin
                if (slot_we[k]) rx_q[k] <= rx_stage[k];
            end
        end
    end

    // Read mux over the eight offsets
    always_comb begin
        case (rd_addr)
            OFS_CTRL: rd_data = {busy, 3'b000, cfg.rcnt, cfg.frame};
            OFS_OPC:  rd_data = opcode;
            OFS_ALO:  rd_data = addr_lo;
            OFS_AMID: rd_data = addr_mid;
            OFS_AHI:  rd_data = addr_hi;
            OFS_RX0:  rd_data = rx_q[0];
            OFS_RX1:  rd_data = rx_q[1];
            default:  rd_data = rx_q[2];
        endcase
    end

    // R7
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable({opcode, addr_hi, addr_mid, addr_lo, data_byte, cfg}));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx_q));

endmodule

// File: rtl/spi_cmd_engine.sv
// Top of the short SPI command engine: register file, half-period timer
// and bit sequencer. Assumes a synchronous bus with combinational reads.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int unsigned SLOW_HALF = 4,
    parameter int unsigned FAST_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    output logic [7:0] bus_rdata,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    xfer_cfg_t              cfg;
    logic                   start, start_fast, busy, done, tick, fast_sel;
    logic [7:0]             opcode, addr_hi, addr_mid, addr_lo, data_byte;
    logic [MAX_RX-1:0][7:0] rx_stage;

    // The rate comes from the write itself on the start cycle
    assign fast_sel = start ? start_fast : cfg.fast;

    spi_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .rd_addr(bus_addr), .busy(busy), .done(done),
        .rx_stage(rx_stage), .rd_data(bus_rdata), .opcode(opcode),
        .addr_hi(addr_hi), .addr_mid(addr_mid), .addr_lo(addr_lo),
        .data_byte(data_byte), .cfg(cfg), .start(start), .start_fast(start_fast)
    );

    spi_half_timer #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(start), .fast_sel(fast_sel),
        .run(busy), .tick(tick)
    );

    spi_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .opcode(opcode),
        .addr_hi(addr_hi), .addr_mid(addr_mid), .addr_lo(addr_lo),
        .data_byte(data_byte), .tick(tick), .miso(spi_miso), .cs_n(spi_cs_n),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(busy), .done(done),
        .rx_stage(rx_stage)
    );

    // R6
    busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !spi_cs_n);

endmodule

// File: tb/tb_spi_cmd_engine.sv
// Scoreboard bench: the driver pushes expected MOSI bytes into a queue,
// and a device model on the wire pops and compares each byte it receives.
module tb_spi_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW = 4;
    localparam int FAST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    spi_cmd_engine #(.SLOW_HALF(SLOW), .FAST_HALF(FAST)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Device model and scoreboard monitor state
    logic [7:0] exp_q[$];
    logic [7:0] stream [0:7];
    logic [7:0] sh, e;
    logic [7:0] rx_model [0:2];
    int exp_half = SLOW;
    int cyc = 0, last_evt = 0, bitn = 0, rises = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !spi_cs_n) begin
            bitn = 0; rises = 0; last_evt = cyc;
            spi_miso = stream[0][7];
        end else if (!spi_cs_n && !prev_sclk && spi_sclk) begin
            chk(cyc - last_evt == exp_half, "R8", "half period before rise", cyc - last_evt, exp_half);
            last_evt = cyc;
            sh = {sh[6:0], spi_mosi};
            bitn++; rises++;
            if (bitn % 8 == 0) begin
                if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected MOSI byte", sh, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(sh == e, "R2", "MOSI byte (R3 order)", sh, e);
                end
            end
        end else if (!spi_cs_n && prev_sclk && !spi_sclk) begin
            chk(cyc - last_evt == exp_half, "R5", "half period before fall", cyc - last_evt, exp_half);
            last_evt = cyc;
            if (bitn < 64) spi_miso = stream[bitn / 8][7 - (bitn % 8)];
        end
        if (!prev_cs && spi_cs_n)
            chk(cyc - last_evt == exp_half, "R8", "trailing half period", cyc - last_evt, exp_half);
        if (!spi_cs_n && spi_sclk && prev_sclk && spi_mosi != prev_mosi)
            chk(1'b0, "R8", "MOSI moved while SCLK high", spi_mosi, prev_mosi);
        if (spi_cs_n && spi_sclk)
            chk(1'b0, "R8", "SCLK high while deselected", 1, 0);
        prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_txn(input logic [1:0] frame, input logic [1:0] rc, input bit fast,
                           input logic [7:0] op, hi, mid, lo, dat, r0, r1, r2,
                           input bit meddle);
        logic [7:0] v;
        logic [7:0] resp [0:2];
        int txn;
        resp[0] = r0; resp[1] = r1; resp[2] = r2;
        wr(3'd1, op); wr(3'd4, hi); wr(3'd3, mid); wr(3'd2, lo); wr(3'd7, dat);
        txn = (frame == 2'd0) ? 1 : (frame == 2'd1) ? 2 : (frame == 2'd2) ? 4 : 5;
        for (int k = 0; k < 8; k++) stream[k] = (k < txn) ? 8'hC3 ^ 8'(k) : resp[(k - txn) % 3];
        exp_half = fast ? FAST : SLOW;
        exp_q.push_back(op);
        if (frame == 2'd1) exp_q.push_back(dat);
        if (frame[1]) begin exp_q.push_back(hi); exp_q.push_back(mid); exp_q.push_back(lo); end
        if (frame == 2'd3) exp_q.push_back(dat);
        for (int k = 0; k < rc; k++) exp_q.push_back(8'h00);
        wr(3'd0, {fast ? 4'h5 : 4'h4, rc, frame});
        rd(3'd0, v);
        chk(v[7] == 1'b1, "R6", "busy after start", v[7], 1);
        chk(v[3:0] == {rc, frame}, "R6", "control readback", v[3:0], {rc, frame});
        if (meddle) begin
            wr(3'd0, 8'h5F); wr(3'd1, 8'hEE); wr(3'd7, 8'h11);
        end
        for (int k = 0; k < rc; k++) rx_model[k] = resp[k];
        for (int t = 0; t < 3000; t++) begin
            rd(3'd0, v);
            if (!v[7]) break;
            @(negedge clk);
        end
        // R9: sampled in the first cycle that busy reads low
        chk(spi_cs_n == 1'b1, "R6", "CS high when busy low", spi_cs_n, 1);
        rd(3'd5, v); chk(v == rx_model[0], "R9", "response slot 0 (R4)", v, rx_model[0]);
        rd(3'd6, v); chk(v == rx_model[1], "R9", "response slot 1 (R4)", v, rx_model[1]);
        rd(3'd7, v); chk(v == rx_model[2], "R9", "response slot 2 (R4)", v, rx_model[2]);
        chk(exp_q.size() == 0, "R2", "bytes left unsent", exp_q.size(), 0);
        chk(rises == 8 * (txn + rc), "R10", "rising edge count", rises, 8 * (txn + rc));
        if (meddle) begin
            rd(3'd1, v); chk(v == op, "R7", "opcode frozen", v, op);
            rd(3'd0, v); chk(v[3:0] == {rc, frame}, "R7", "control frozen", v[3:0], {rc, frame});
            repeat (30) @(negedge clk);
            chk(spi_cs_n == 1'b1, "R7", "no second transfer", spi_cs_n, 1);
        end
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=idle");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        for (int k = 0; k < 3; k++) rx_model[k] = 8'h00;
        for (int k = 0; k < 8; k++) stream[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 8'h00, "R1", "register after reset", v, 0);
        end
        chk(spi_cs_n == 1'b1, "R1", "CS after reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "SCLK after reset", spi_sclk, 0);

        run_txn(2'd0, 2'd1, 1'b0, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h00, 1'b0);
        run_txn(2'd1, 2'd0, 1'b1, 8'h3C, 8'h00, 8'h00, 8'h00, 8'hB7, 8'h00, 8'h00, 8'h00, 1'b0);
        run_txn(2'd2, 2'd3, 1'b0, 8'h0B, 8'h12, 8'h34, 8'h56, 8'hFF, 8'hA1, 8'h82, 8'h7C, 1'b0);
        run_txn(2'd3, 2'd2, 1'b1, 8'h02, 8'hE0, 8'h01, 8'h80, 8'h6D, 8'h44, 8'h99, 8'h00, 1'b0);
        run_txn(2'd0, 2'd0, 1'b1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
        run_txn(2'd3, 2'd3, 1'b0, 8'hD8, 8'hAB, 8'hCD, 8'hEF, 8'h5A, 8'h13, 8'h57, 8'h9B, 1'b1);

        // R5: a control write with another start code stays idle
        rd(3'd0, v);
        wr(3'd0, 8'h3B);
        repeat (12) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R5", "no transfer on bad start code", spi_cs_n, 1);
        begin
            logic [7:0] w;
            rd(3'd0, w);
            chk(w == v, "R5", "control unchanged by bad code", w, v);
        end

        // R4: writes to the first two response slots are ignored
        wr(3'd5, 8'h77);
        wr(3'd6, 8'h88);
        rd(3'd5, v); chk(v == rx_model[0], "R4", "slot 0 write ignored", v, rx_model[0]);
        rd(3'd6, v); chk(v == rx_model[1], "R4", "slot 1 write ignored", v, rx_model[1]);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule